// File: doc/BRIEF.md
# External Bus Access Width Translator

This block converts single accesses from a 32-bit internal bus into the sequence of narrow transactions an external memory port can carry. Four banks share the external port. Each bank holds a device that is either 8 or 16 bits wide, with or without byte-lane enables, and a bank may be marked as NAND. The block may split an access into several beats at incrementing device addresses, use a single byte-lane beat, perform a read-modify-write, or refuse the access with a fault. It selects among these from the access size and the configuration of the addressed bank.

On the internal side a request is taken only while `req_ready` is high. The result comes back as a one-cycle `done` pulse carrying the assembled read data or an error flag. On the external side each beat is a request held until the memory acknowledges it. The beat carries the device-unit address, write data, active-low lane enables and the active-low select of the addressed bank.

Top module: `ext_width_xlate`

## Requirements
- R1: With `cfg_per_bank` = 0, bit 0 of `cfg_wide` and `cfg_lanes` sets the width and lane support of every bank. With `cfg_per_bank` = 1, bit n of each vector applies to bank n. `cfg_nand` and `cfg_bank_en` are always per bank.
- R2: On an 8-bit device (`cfg_wide` bit 0), an access of size code 0 (8 bits), 1 (16 bits) or 2 (32 bits) is carried out as 1, 2 or 4 beats. The beats go to device addresses equal to the byte address plus 0, 1, 2, 3, and the least significant byte goes first.
- R3: On a 16-bit device (`cfg_wide` bit 1), a 32-bit access takes 2 beats and a 16-bit access takes 1 beat. The device address is the byte address shifted right by one, plus the beat number.
- R4: Read data is assembled with the lower device address in the lower bits of `done_rdata`. For 8- and 16-bit reads the result is in the low bits and the upper bits are zero. Lanes a device does not drive are ignored.
- R5: An 8-bit access to a 16-bit device with byte lanes is one beat. The lane enable `ext_be_n` is active low: `2'b10` selects the low lane when address bit 0 is 0, and `2'b01` selects the high lane when it is 1.
- R6: An 8-bit read from a 16-bit device without byte lanes is one full-width beat (`ext_be_n` = `2'b00`). The byte chosen by address bit 0 is returned.
- R7: An 8-bit write to a 16-bit non-NAND device without byte lanes is one full-width read followed by one full-width write to the same address, and the other byte keeps its value.
- R8: An 8-bit write to a 16-bit NAND bank ends with `done_err` = 1 and issues no external beat. Wider writes to that bank proceed normally.
- R9: Any access to a bank whose `cfg_bank_en` bit is 0 ends with `done_err` = 1 and no chip select is asserted.
- R10: While `ext_req` is high, only the addressed bank's `ext_cs_n` bit is low. While it is low, all bits are high.
- R11: `done` is high for exactly one cycle per accepted request, and `req_ready` is low from acceptance until after `done`.
- R12: Beats to an 8-bit device carry the byte on `ext_wdata[7:0]` with `ext_be_n` = `2'b10`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_per_bank | input | 1 | 1: per-bank width/lane bits; 0: bit 0 shared by all banks |
| cfg_wide | input | NBANK | 1: 16-bit device, 0: 8-bit device |
| cfg_lanes | input | NBANK | Device supports byte-lane enables |
| cfg_nand | input | NBANK | Bank holds a NAND device |
| cfg_bank_en | input | NBANK | Bank enable |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request will be taken |
| req_write | input | 1 | 1 write, 0 read |
| req_size | input | 2 | 0: 8 bits, 1: 16 bits, 2: 32 bits |
| req_bank | input | BANK_W | Target bank |
| req_addr | input | ADDR_W | Byte address within the bank |
| req_wdata | input | 32 | Write data, low bits used for narrow sizes |
| done | output | 1 | One-cycle completion pulse |
| done_err | output | 1 | Completion is a fault |
| done_rdata | output | 32 | Assembled read data |
| ext_req | output | 1 | External beat request |
| ext_ack | input | 1 | External beat acknowledge |
| ext_we | output | 1 | Beat is a write |
| ext_addr | output | ADDR_W | Device-unit address |
| ext_wdata | output | 16 | Beat write data |
| ext_be_n | output | 2 | Active-low lane enables |
| ext_cs_n | output | NBANK | Active-low bank selects |
| ext_rdata | input | 16 | Beat read data |

## Verification
The bench targets the cases where the planning logic must pick a different route. A narrow write to a lane-less 16-bit bank is one: a design that skips the read phase would overwrite the neighbouring byte. A narrow NAND write is another: an erroneous design would issue a beat or drop the fault. The shared-configuration mode is tested by changing bank 0's bits only. A design that ignores the mode bit would leave bank 1's beat count unchanged. The model drives junk on the upper lane of 8-bit devices and checks byte ordering and address increments. This catches designs that swap bytes, misplace the lane select, or shift the address for the wrong device width.

// File: rtl/xw_pkg.sv
package xw_pkg;
   localparam int WORD_W = 32;
   localparam int HALF_W = 16;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_HALF = 2'd1,
      SZ_WORD = 2'd2
   } xw_size_e;

   typedef struct packed {
      logic en;
      logic wide;
      logic lanes;
      logic nand_bank;
   } xw_bank_t;

   typedef struct packed {
      logic       fault;
      logic       dev16;
      logic       rmw;
      logic       byte_on16;
      logic       use_lane;
      logic       lane_hi;
      logic [2:0] beats;
   } xw_plan_t;
endpackage

// File: rtl/xw_cfg_sel.sv
module xw_cfg_sel #(
   parameter int NBANK  = 4,
   parameter int BANK_W = 2
) (
   input  logic                cfg_per_bank,
   input  logic [NBANK-1:0]    cfg_wide,
   input  logic [NBANK-1:0]    cfg_lanes,
   input  logic [NBANK-1:0]    cfg_nand,
   input  logic [NBANK-1:0]    cfg_bank_en,
   input  logic [BANK_W-1:0]   bank,
   output xw_pkg::xw_bank_t    sel_cfg
);
   logic [NBANK-1:0] eff_wide;
   logic [NBANK-1:0] eff_lanes;

   for (genvar b = 0; b < NBANK; b++) begin : g_bank
      if (b == 0) begin : g_base
         assign eff_wide[b]  = cfg_wide[0];
         assign eff_lanes[b] = cfg_lanes[0];
      end else begin : g_other
         assign eff_wide[b]  = cfg_per_bank ? cfg_wide[b]  : cfg_wide[0];
         assign eff_lanes[b] = cfg_per_bank ? cfg_lanes[b] : cfg_lanes[0];
      end
   end

   always_comb begin
      sel_cfg.en        = cfg_bank_en[bank];
      sel_cfg.wide      = eff_wide[bank];
      sel_cfg.lanes     = eff_lanes[bank];
      sel_cfg.nand_bank = cfg_nand[bank];
   end
endmodule

// File: rtl/xw_plan.sv
module xw_plan (
   input  xw_pkg::xw_bank_t cfg,
   input  logic             write,
   input  logic [1:0]       size,
   input  logic             addr_lsb,
   output xw_pkg::xw_plan_t plan
);
   import xw_pkg::*;

   logic is_byte;
   logic is_word;

   always_comb begin
      is_byte = (size == SZ_BYTE);
      is_word = (size == SZ_WORD) || (size == 2'd3);

      plan.fault     = !cfg.en || (cfg.nand_bank && cfg.wide && write && is_byte);
      plan.dev16     = cfg.wide;
      plan.byte_on16 = cfg.wide && is_byte;
      plan.use_lane  = cfg.wide && is_byte && cfg.lanes;
      plan.lane_hi   = addr_lsb;
      plan.rmw       = cfg.wide && is_byte && !cfg.lanes && write && !plan.fault;

      if (!cfg.wide) begin
         if (is_byte)      plan.beats = 3'd1;
         else if (is_word) plan.beats = 3'd4;
         else              plan.beats = 3'd2;
      end else begin
         if (is_word || plan.rmw) plan.beats = 3'd2;
         else                     plan.beats = 3'd1;
      end
   end
endmodule

// File: rtl/xw_seq.sv
module xw_seq #(
   parameter int ADDR_W = 24,
   parameter int NBANK  = 4,
   parameter int BANK_W = 2
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       start,
   input  xw_pkg::xw_plan_t           plan,
   input  logic                       write,
   input  logic [BANK_W-1:0]          bank,
   input  logic [ADDR_W-1:0]          addr,
   input  logic [xw_pkg::WORD_W-1:0]  wdata,
   output logic                       ready,
   output logic                       done,
   output logic                       done_err,
   output logic [xw_pkg::WORD_W-1:0]  done_rdata,
   output logic                       ext_req,
   input  logic                       ext_ack,
   output logic                       ext_we,
   output logic [ADDR_W-1:0]          ext_addr,
   output logic [xw_pkg::HALF_W-1:0]  ext_wdata,
   output logic [1:0]                 ext_be_n,
   output logic [NBANK-1:0]           ext_cs_n,
   input  logic [xw_pkg::HALF_W-1:0]  ext_rdata
);
   import xw_pkg::*;

   typedef enum logic [1:0] {ST_IDLE, ST_BEAT, ST_DONE} st_e;

   st_e                 st_q;
   xw_plan_t            plan_q;
   logic                write_q;
   logic                err_q;
   logic [BANK_W-1:0]   bank_q;
   logic [ADDR_W-1:0]   base_q;
   logic [WORD_W-1:0]   wdata_q;
   logic [WORD_W-1:0]   rdata_q;
   logic [HALF_W-1:0]   merge_q;
   logic [1:0]          beat_q;

   logic                in_beat;
   logic                rmw_rd;
   logic                last_beat;
   logic [7:0]          rd_byte;

   assign in_beat   = (st_q == ST_BEAT);
   assign rmw_rd    = plan_q.rmw && (beat_q == 2'd0);
   assign last_beat = ({1'b0, beat_q} == (plan_q.beats - 3'd1));
   assign rd_byte   = plan_q.lane_hi ? ext_rdata[15:8] : ext_rdata[7:0];

   assign ready      = (st_q == ST_IDLE);
   assign done       = (st_q == ST_DONE);
   assign done_err   = err_q;
   assign done_rdata = rdata_q;
   assign ext_req    = in_beat;
   assign ext_we     = in_beat && write_q && !rmw_rd;
   assign ext_addr   = base_q + (plan_q.rmw ? '0 : {{(ADDR_W-2){1'b0}}, beat_q});

   always_comb begin
      if (!plan_q.dev16) begin
         ext_wdata = {8'h00, wdata_q[{beat_q, 3'b000} +: 8]};
         ext_be_n  = 2'b10;
      end else if (plan_q.rmw) begin
         ext_wdata = merge_q;
         ext_be_n  = 2'b00;
      end else if (plan_q.use_lane) begin
         ext_wdata = {2{wdata_q[7:0]}};
         ext_be_n  = plan_q.lane_hi ? 2'b01 : 2'b10;
      end else begin
         ext_wdata = wdata_q[{beat_q[0], 4'b0000} +: 16];
         ext_be_n  = 2'b00;
      end
   end

   for (genvar b = 0; b < NBANK; b++) begin : g_cs
      assign ext_cs_n[b] = !(in_beat && (bank_q == BANK_W'(b)));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= ST_IDLE;
         plan_q  <= '0;
         write_q <= 1'b0;
         err_q   <= 1'b0;
         bank_q  <= '0;
         base_q  <= '0;
         wdata_q <= '0;
         rdata_q <= '0;
         merge_q <= '0;
         beat_q  <= '0;
      end else begin
         case (st_q)
            ST_IDLE: begin
               if (start) begin
                  plan_q  <= plan;
                  write_q <= write;
                  bank_q  <= bank;
                  base_q  <= plan.dev16 ? (addr >> 1) : addr;
                  wdata_q <= wdata;
                  rdata_q <= '0;
                  beat_q  <= '0;
                  err_q   <= plan.fault;
                  st_q    <= plan.fault ? ST_DONE : ST_BEAT;
               end
            end
            ST_BEAT: begin
               if (ext_ack) begin
                  if (rmw_rd) begin
                     merge_q <= plan_q.lane_hi ? {wdata_q[7:0], ext_rdata[7:0]}
                                               : {ext_rdata[15:8], wdata_q[7:0]};
                  end
                  if (!write_q) begin
                     if (!plan_q.dev16)
                        rdata_q[{beat_q, 3'b000} +: 8] <= ext_rdata[7:0];
                     else if (plan_q.byte_on16)
                        rdata_q[7:0] <= rd_byte;
                     else
                        rdata_q[{beat_q[0], 4'b0000} +: 16] <= ext_rdata;
                  end
                  if (last_beat) st_q <= ST_DONE;
                  else           beat_q <= beat_q + 2'd1;
               end
            end
            default: begin
               st_q <= ST_IDLE;
            end
         endcase
      end
   end
endmodule

// File: rtl/ext_width_xlate.sv
module ext_width_xlate #(
   parameter int ADDR_W = 24,
   parameter int NBANK  = 4,
   localparam int BANK_W = $clog2(NBANK)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cfg_per_bank,
   input  logic [NBANK-1:0]   cfg_wide,
   input  logic [NBANK-1:0]   cfg_lanes,
   input  logic [NBANK-1:0]   cfg_nand,
   input  logic [NBANK-1:0]   cfg_bank_en,
   input  logic               req_valid,
   output logic               req_ready,
   input  logic               req_write,
   input  logic [1:0]         req_size,
   input  logic [BANK_W-1:0]  req_bank,
   input  logic [ADDR_W-1:0]  req_addr,
   input  logic [31:0]        req_wdata,
   output logic               done,
   output logic               done_err,
   output logic [31:0]        done_rdata,
   output logic               ext_req,
   input  logic               ext_ack,
   output logic               ext_we,
   output logic [ADDR_W-1:0]  ext_addr,
   output logic [15:0]        ext_wdata,
   output logic [1:0]         ext_be_n,
   output logic [NBANK-1:0]   ext_cs_n,
   input  logic [15:0]        ext_rdata
);
   if (NBANK < 2) begin : g_bad_nbank
      $error("ext_width_xlate: NBANK must be at least 2");
   end
   if (ADDR_W < 4) begin : g_bad_addr
      $error("ext_width_xlate: ADDR_W must be at least 4");
   end

   xw_pkg::xw_bank_t sel_cfg;
   xw_pkg::xw_plan_t plan;
   logic             start;

   assign start = req_valid && req_ready;

   xw_cfg_sel #(.NBANK(NBANK), .BANK_W(BANK_W)) u_cfg (
      .cfg_per_bank (cfg_per_bank),
      .cfg_wide     (cfg_wide),
      .cfg_lanes    (cfg_lanes),
      .cfg_nand     (cfg_nand),
      .cfg_bank_en  (cfg_bank_en),
      .bank         (req_bank),
      .sel_cfg      (sel_cfg)
   );

   xw_plan u_plan (
      .cfg      (sel_cfg),
      .write    (req_write),
      .size     (req_size),
      .addr_lsb (req_addr[0]),
      .plan     (plan)
   );

   xw_seq #(.ADDR_W(ADDR_W), .NBANK(NBANK), .BANK_W(BANK_W)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .plan       (plan),
      .write      (req_write),
      .bank       (req_bank),
      .addr       (req_addr),
      .wdata      (req_wdata),
      .ready      (req_ready),
      .done       (done),
      .done_err   (done_err),
      .done_rdata (done_rdata),
      .ext_req    (ext_req),
      .ext_ack    (ext_ack),
      .ext_we     (ext_we),
      .ext_addr   (ext_addr),
      .ext_wdata  (ext_wdata),
      .ext_be_n   (ext_be_n),
      .ext_cs_n   (ext_cs_n),
      .ext_rdata  (ext_rdata)
   );
endmodule

// File: rtl/ext_width_xlate_chk.sv
module ext_width_xlate_chk #(
   parameter int ADDR_W = 24,
   parameter int NBANK  = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_ready,
   input logic              done,
   input logic              ext_req,
   input logic              ext_ack,
   input logic [ADDR_W-1:0] ext_addr,
   input logic [1:0]        ext_be_n,
   input logic [NBANK-1:0]  ext_cs_n
);
   // R10
   cs_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ext_req |-> ($countones(~ext_cs_n) == 1));

   // R10
   cs_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ext_req |-> (&ext_cs_n));

   // R11
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R11
   busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ext_req || done) |-> !req_ready);

   // R5
   some_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ext_req |-> (ext_be_n != 2'b11));

   // R2
   beat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ext_req && !ext_ack) |=> (ext_req && $stable(ext_addr)));
endmodule

bind ext_width_xlate ext_width_xlate_chk #(.ADDR_W(ADDR_W), .NBANK(NBANK)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_ready (req_ready),
   .done      (done),
   .ext_req   (ext_req),
   .ext_ack   (ext_ack),
   .ext_addr  (ext_addr),
   .ext_be_n  (ext_be_n),
   .ext_cs_n  (ext_cs_n)
);

// File: tb/ext_width_xlate_bench.sv
module ext_width_xlate_bench;
   localparam int CLK_PERIOD = 10;
   localparam int ADDR_W     = 16;
   localparam int NBANK      = 4;

   logic              clk;
   logic              rst_n;
   logic              cfg_per_bank;
   logic [NBANK-1:0]  cfg_wide, cfg_lanes, cfg_nand, cfg_bank_en;
   logic              req_valid, req_ready, req_write;
   logic [1:0]        req_size;
   logic [1:0]        req_bank;
   logic [ADDR_W-1:0] req_addr;
   logic [31:0]       req_wdata;
   logic              done, done_err;
   logic [31:0]       done_rdata;
   logic              ext_req, ext_ack, ext_we;
   logic [ADDR_W-1:0] ext_addr;
   logic [15:0]       ext_wdata, ext_rdata;
   logic [1:0]        ext_be_n;
   logic [NBANK-1:0]  ext_cs_n;

   int n_checks = 0;
   int n_errors = 0;

   logic [7:0] mem [0:3][0:63];
   int                beats, nrd, nwr;
   logic [1:0]        last_be;
   logic [ADDR_W-1:0] first_addr;
   bit                cs_bad, cs_any, ready_bad, be8_bad;
   int                cur_bank;
   bit                cur_wide;
   logic [31:0]       res_data;
   logic              res_err;
   logic              done_again;

   ext_width_xlate #(.ADDR_W(ADDR_W), .NBANK(NBANK)) u_ext_width_xlate (.*);

   initial begin
      clk = 1'b0;
      forever #(CLK_PERIOD/2) clk = ~clk;
   end

   // external memory model and bus monitor, all activity on the falling edge
   initial begin
      ext_ack   = 1'b0;
      ext_rdata = '0;
      forever begin
         @(negedge clk);
         if (ext_cs_n != '1) cs_any = 1'b1;
         if (ext_req && (ext_cs_n != ~(4'b0001 << cur_bank))) cs_bad = 1'b1;
         if (!ext_req && (ext_cs_n != '1)) cs_bad = 1'b1;
         if (ext_req && req_ready) ready_bad = 1'b1;
         if (ext_ack) begin
            ext_ack = 1'b0;
         end else if (ext_req) begin
            if (beats == 0) first_addr = ext_addr;
            beats++;
            last_be = ext_be_n;
            if (!cur_wide) begin
               if (ext_be_n != 2'b10) be8_bad = 1'b1;
               if (ext_we) mem[cur_bank][ext_addr[5:0]] = ext_wdata[7:0];
               else ext_rdata = {8'hC5, mem[cur_bank][ext_addr[5:0]]};
            end else begin
               if (ext_we) begin
                  if (!ext_be_n[0]) mem[cur_bank][{ext_addr[4:0], 1'b0}] = ext_wdata[7:0];
                  if (!ext_be_n[1]) mem[cur_bank][{ext_addr[4:0], 1'b1}] = ext_wdata[15:8];
               end else begin
                  ext_rdata = {mem[cur_bank][{ext_addr[4:0], 1'b1}],
                               mem[cur_bank][{ext_addr[4:0], 1'b0}]};
               end
            end
            if (ext_we) nwr++; else nrd++;
            ext_ack = 1'b1;
         end
      end
   end

   initial begin
      #(CLK_PERIOD * 150000);
      n_checks++;
      n_errors++;
      $display("FAIL R11 watchdog: actual=expired expected=completion");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic access(input bit wr, input logic [1:0] sz, input int bank,
                         input logic [ADDR_W-1:0] addr, input logic [31:0] wd,
                         input bit wide);
      int cnt;
      beats = 0; nrd = 0; nwr = 0; last_be = 2'b11; first_addr = '0;
      cs_bad = 0; cs_any = 0; ready_bad = 0; be8_bad = 0;
      cur_bank = bank; cur_wide = wide;
      @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_size = sz;
      req_bank = 2'(bank); req_addr = addr; req_wdata = wd;
      @(negedge clk);
      req_valid = 1'b0;
      cnt = 0;
      while (!done && cnt < 200) begin
         @(negedge clk);
         cnt++;
      end
      if (cnt >= 200) chk("R11", "access timeout", 32'd1, 32'd0);
      res_data = done_rdata;
      res_err  = done_err;
      @(negedge clk);
      done_again = done;
   endtask

   task automatic t_reset;
      chk("R10", "reset cs", 32'(ext_cs_n), 32'hF);
      chk("R11", "reset ready", 32'(req_ready), 32'd1);
      chk("R11", "reset done", 32'(done), 32'd0);
      chk("R10", "reset ext_req", 32'(ext_req), 32'd0);
   endtask

   task automatic t_narrow_dev;
      access(1, 2'd2, 0, 16'h0010, 32'hA1B2C3D4, 0);
      chk("R2", "w32 beats", beats, 4);
      chk("R2", "w32 first addr", 32'(first_addr), 32'h10);
      chk("R2", "w32 byte order", {mem[0][19], mem[0][18], mem[0][17], mem[0][16]}, 32'hA1B2C3D4);
      chk("R12", "narrow lanes", 32'(be8_bad), 0);
      chk("R10", "cs w32", 32'(cs_bad), 0);
      access(0, 2'd2, 0, 16'h0010, 32'h0, 0);
      chk("R2", "r32 beats", beats, 4);
      chk("R4", "r32 data", res_data, 32'hA1B2C3D4);
      access(0, 2'd1, 0, 16'h0012, 32'h0, 0);
      chk("R2", "r16 beats", beats, 2);
      chk("R4", "r16 data", res_data, 32'h0000A1B2);
      access(0, 2'd0, 0, 16'h0013, 32'h0, 0);
      chk("R4", "r8 data", res_data, 32'h000000A1);
      chk("R12", "r8 lane", 32'(last_be), 32'h2);
   endtask

   task automatic t_wide_dev;
      access(1, 2'd2, 1, 16'h0020, 32'h11223344, 1);
      chk("R3", "w32 beats", beats, 2);
      chk("R3", "w32 first addr", 32'(first_addr), 32'h10);
      chk("R3", "w32 bytes", {mem[1][35], mem[1][34], mem[1][33], mem[1][32]}, 32'h11223344);
      access(0, 2'd1, 1, 16'h0022, 32'h0, 1);
      chk("R3", "r16 beats", beats, 1);
      chk("R3", "r16 addr", 32'(first_addr), 32'h11);
      chk("R4", "r16 data", res_data, 32'h00001122);
   endtask

   task automatic t_lanes;
      access(1, 2'd0, 1, 16'h0021, 32'h000000EE, 1);
      chk("R5", "w8 beats", beats, 1);
      chk("R5", "w8 hi lane", 32'(last_be), 32'h1);
      chk("R5", "w8 target", 32'(mem[1][33]), 32'hEE);
      chk("R5", "w8 neighbour", 32'(mem[1][32]), 32'h44);
      access(0, 2'd0, 1, 16'h0020, 32'h0, 1);
      chk("R5", "r8 lo lane", 32'(last_be), 32'h2);
      chk("R5", "r8 data", res_data, 32'h00000044);
      chk("R10", "cs lanes", 32'(cs_bad), 0);
   endtask

   task automatic t_no_lanes;
      access(1, 2'd2, 2, 16'h0030, 32'h55667788, 1);
      access(1, 2'd0, 2, 16'h0031, 32'h00000099, 1);
      chk("R7", "rmw beats", beats, 2);
      chk("R7", "rmw reads", nrd, 1);
      chk("R7", "rmw writes", nwr, 1);
      chk("R7", "rmw addr", 32'(first_addr), 32'h18);
      chk("R7", "rmw result", {mem[2][49], mem[2][48]}, 32'h9988);
      access(0, 2'd0, 2, 16'h0031, 32'h0, 1);
      chk("R6", "r8 beats", beats, 1);
      chk("R6", "r8 full lanes", 32'(last_be), 32'h0);
      chk("R6", "r8 hi data", res_data, 32'h00000099);
      access(0, 2'd0, 2, 16'h0030, 32'h0, 1);
      chk("R6", "r8 lo data", res_data, 32'h00000088);
   endtask

   task automatic t_nand;
      access(1, 2'd0, 3, 16'h0004, 32'h00000077, 1);
      chk("R8", "fault", 32'(res_err), 1);
      chk("R8", "no beats", beats, 0);
      chk("R8", "no cs", 32'(cs_any), 0);
      access(1, 2'd1, 3, 16'h0004, 32'h0000BEEF, 1);
      chk("R8", "w16 ok", 32'(res_err), 0);
      chk("R8", "w16 beats", beats, 1);
      chk("R8", "w16 data", {mem[3][5], mem[3][4]}, 32'hBEEF);
   endtask

   task automatic t_disabled;
      cfg_bank_en[1] = 1'b0;
      access(0, 2'd2, 1, 16'h0020, 32'h0, 1);
      chk("R9", "fault", 32'(res_err), 1);
      chk("R9", "no beats", beats, 0);
      chk("R9", "no cs", 32'(cs_any), 0);
      cfg_bank_en[1] = 1'b1;
   endtask

   task automatic t_shared_cfg;
      cfg_per_bank = 1'b0;
      cfg_wide[0] = 1'b0; cfg_lanes[0] = 1'b0;
      access(0, 2'd2, 1, 16'h0020, 32'h0, 0);
      chk("R1", "shared narrow beats", beats, 4);
      chk("R1", "shared narrow data", res_data, 32'h1122EE44);
      cfg_wide[0] = 1'b1;
      access(0, 2'd1, 0, 16'h0010, 32'h0, 1);
      chk("R1", "shared wide beats", beats, 1);
      chk("R1", "shared wide addr", 32'(first_addr), 32'h8);
      chk("R1", "shared wide data", res_data, 32'h0000C3D4);
      cfg_per_bank = 1'b1;
      cfg_wide[0] = 1'b0;
   endtask

   task automatic t_handshake;
      access(0, 2'd2, 0, 16'h0010, 32'h0, 0);
      chk("R11", "ready low when busy", 32'(ready_bad), 0);
      chk("R11", "done one cycle", 32'(done_again), 0);
      chk("R11", "ready after done", 32'(req_ready), 1);
   endtask

   initial begin
      rst_n = 1'b0;
      cfg_per_bank = 1'b1;
      cfg_wide    = 4'b1110;
      cfg_lanes   = 4'b0010;
      cfg_nand    = 4'b1000;
      cfg_bank_en = 4'b1111;
      req_valid = 1'b0; req_write = 1'b0; req_size = 2'd0;
      req_bank = '0; req_addr = '0; req_wdata = '0;
      for (int b = 0; b < 4; b++)
         for (int a = 0; a < 64; a++) mem[b][a] = 8'h00;
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_narrow_dev();
      t_wide_dev();
      t_lanes();
      t_no_lanes();
      t_nand();
      t_disabled();
      t_shared_cfg();
      t_handshake();
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end
endmodule